// File: doc/BRIEF.md
# I2S Bit and Frame Clock Generator

This block turns an incoming audio master clock into the two timing signals an I2S link needs: the serial bit clock and the left/right frame clock. The master clock is the block's own clock. The bit clock is the master clock divided by 2 or by 4. The frame clock is derived from the bit clock and is that clock divided by 32, 64 or 128. One enable bit starts and stops both outputs together. Every output is a register, so no generated clock passes through combinational logic.

The settings sit in one 8-bit control register. Writes to it are guarded: a write to the control register takes effect only if the write just before it went to the key address and carried the key value. Any accepted control write restarts both dividers from zero. Left and right half-frames therefore begin at a known point after software changes the rate.

Control register layout: bit 0 enables the outputs. Bit 1 selects the bit-clock divider (0 gives /2, 1 gives /4). Bits 3:2 hold the frame ratio. Bits 7:4 are stored and read back but have no effect.

Top module: `i2s_clkgen`

## Requirements
- R1: After a synchronous active-low reset, the control register reads 0x00, the key is not armed, and `sclk_o` and `lrclk_o` are both low.
- R2: With bit 1 clear and the block enabled, `sclk_o` toggles on every master clock edge, giving a period of 2 master cycles. Its first rise comes 1 cycle after the restart edge.
- R3: With bit 1 set and the block enabled, `sclk_o` toggles every 2 master cycles, giving a period of 4. Its first rise comes 2 cycles after the restart edge.
- R4: The ratio field in bits 3:2 sets the frame length: code 01 gives 32 bit-clock periods, 10 gives 64 and 11 gives 128. `lrclk_o` has a 50% duty cycle and changes level only on a falling edge of `sclk_o`.
- R5: Ratio code 00 holds `lrclk_o` low while `sclk_o` keeps running.
- R6: While bit 0 is clear, `sclk_o` and `lrclk_o` are both held low.
- R7: A write to `reg_sel`=1 updates the control register only if the previous write went to `reg_sel`=0 with data equal to KEY (default 0xA5). Idle cycles between the two writes do not break the sequence. Any other write clears the armed state, and an unaccepted control write leaves the register unchanged.
- R8: An accepted control write restarts both dividers on that edge. The first `lrclk_o` rise then comes exactly half a frame later: (frame bits / 2) × bit-clock period master cycles.
- R9: `reg_rdata` always shows the whole byte of the last accepted control write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock; all logic runs on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | Write target: 0 is the key address, 1 is the control register |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Current control register contents |
| sclk_o | output | 1 | Serial bit clock |
| lrclk_o | output | 1 | Left/right frame clock |

## Verification
The dividers are run with every combination the bench can tell apart: bit-clock /2 and /4 together with frame ratios /32, /64, /128 and the muted code. Each run lasts several frames, so a wrong half-period, a wrong ratio decode, or a frame edge taken on the rising instead of the falling bit-clock edge shows up as a shifted edge against the behavioural model. Control writes are also sent without the key, after a wrong key, after idle gaps and after a repeated key. These show whether the lock accepts exactly the intended sequences. A rewrite of the same settings while running shows whether the dividers restart or carry on.

// File: rtl/i2s_clkgen_pkg.sv
// Shared types for the I2S clock generator.
// Assumes an 8-bit control register; bit positions are fixed by ctl_t.
package i2s_clkgen_pkg;

    localparam int REG_W = 8;

    // Frame ratio codes held in the control register.
    typedef enum logic [1:0] {
        RATIO_MUTE = 2'b00,
        RATIO_32   = 2'b01,
        RATIO_64   = 2'b10,
        RATIO_128  = 2'b11
    } ratio_e;

    // Control register layout, MSB first.
    typedef struct packed {
        logic [3:0] spare;
        ratio_e     ratio;
        logic       slow;
        logic       en;
    } ctl_t;

endpackage

// File: rtl/i2s_cfg_lock.sv
// Control register behind a key-then-write guard.
// Assumes a single writer; the armed state is lost on any write that is not the key.
module i2s_cfg_lock
    import i2s_clkgen_pkg::*;
#(
    parameter logic [REG_W-1:0] KEY = 8'hA5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_i,
    input  logic             sel_i,
    input  logic [REG_W-1:0] wdata_i,
    output ctl_t             cfg_o,
    output logic             accept_o
);

    logic armed_q;
    ctl_t cfg_q;

    assign accept_o = wr_i && sel_i && armed_q;
    assign cfg_o    = cfg_q;

    // Arm on a key write and disarm on any other write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            armed_q <= 1'b0;
        else if (wr_i)
            armed_q <= !sel_i && (wdata_i == KEY);
    end

    // Capture the control byte only when the guard allows it.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cfg_q <= '0;
        else if (accept_o)
            cfg_q <= ctl_t'(wdata_i);
    end

    // R7
    cfg_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && !(sel_i && armed_q)) |=> $stable(cfg_q));

    // R9
    cfg_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept_o |=> (cfg_q == $past(wdata_i)));

endmodule

// File: rtl/i2s_bclk_div.sv
// Bit-clock divider: toggles its output every FAST_HALF or SLOW_HALF
// clock cycles. Assumes run_i drops for at least one cycle whenever slow_i changes.
module i2s_bclk_div #(
    parameter int FAST_HALF = 1,
    parameter int SLOW_HALF = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    input  logic slow_i,
    output logic sclk_o,
    output logic fall_o
);

    localparam int CW = $clog2(SLOW_HALF + 1);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] last_w;
    logic          sclk_q;
    logic          wrap_w;

    assign last_w = slow_i ? CW'(SLOW_HALF - 1) : CW'(FAST_HALF - 1);
    assign wrap_w = (cnt_q == last_w);
    assign fall_o = run_i && wrap_w && sclk_q;
    assign sclk_o = sclk_q;

    // Count master cycles within a half period and flip the bit clock at the end.
    always_ff @(posedge clk) begin
        if (!rst_n || !run_i) begin
            cnt_q  <= '0;
            sclk_q <= 1'b0;
        end else if (wrap_w) begin
            cnt_q  <= '0;
            sclk_q <= ~sclk_q;
        end else begin
            cnt_q  <= cnt_q + 1'b1;
        end
    end

    // R6
    sclk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> !sclk_q);

    // R2
    sclk_div2_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && !slow_i) |=> (sclk_q != $past(sclk_q)));

    // R3
    sclk_div4_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && slow_i && (sclk_q != $past(sclk_q))) |=> $stable(sclk_q));

endmodule

// File: rtl/i2s_frame_div.sv
// Frame-clock divider: counts bit-clock falling edges and flips the frame
// clock every half frame. Assumes fall_i is a one-cycle pulse per bit-clock fall.
module i2s_frame_div
    import i2s_clkgen_pkg::*;
#(
    parameter int BASE_HALF = 16
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   run_i,
    input  logic   fall_i,
    input  ratio_e ratio_i,
    output logic   lrclk_o
);

    localparam int MAX_HALF = BASE_HALF * 4;
    localparam int FW       = $clog2(MAX_HALF);

    logic [FW-1:0] cnt_q;
    logic [FW-1:0] last_w;
    logic          lr_q;
    logic          active_w;

    assign active_w = run_i && (ratio_i != RATIO_MUTE);
    assign lrclk_o  = lr_q;

    // Pick the last bit count of a half frame from the ratio code.
    always_comb begin
        case (ratio_i)
            RATIO_64:  last_w = FW'(BASE_HALF * 2 - 1);
            RATIO_128: last_w = FW'(MAX_HALF - 1);
            default:   last_w = FW'(BASE_HALF - 1);
        endcase
    end

    // Advance on each bit-clock fall and flip the frame clock at a half frame.
    always_ff @(posedge clk) begin
        if (!rst_n || !active_w) begin
            cnt_q <= '0;
            lr_q  <= 1'b0;
        end else if (fall_i) begin
            if (cnt_q == last_w) begin
                cnt_q <= '0;
                lr_q  <= ~lr_q;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    // R5
    lr_mute_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !active_w |=> !lr_q);

    // R4
    lr_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active_w && !fall_i) |=> $stable(lr_q));

endmodule

// File: rtl/i2s_clkgen.sv
// I2S bit- and frame-clock generator top. Runs entirely on the master clock
// and produces both clocks as registered levels. An accepted control write
// restarts both dividers.
module i2s_clkgen
    import i2s_clkgen_pkg::*;
#(
    parameter logic [7:0] KEY       = 8'hA5,
    parameter int         BASE_HALF = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       reg_wr,
    input  logic       reg_sel,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    output logic       sclk_o,
    output logic       lrclk_o
);

    ctl_t cfg;
    logic accept;
    logic run;
    logic fall;

    assign run       = cfg.en && !accept;
    assign reg_rdata = cfg;

    i2s_cfg_lock #(.KEY(KEY)) u_lock (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_i     (reg_wr),
        .sel_i    (reg_sel),
        .wdata_i  (reg_wdata),
        .cfg_o    (cfg),
        .accept_o (accept)
    );

    i2s_bclk_div #(.FAST_HALF(1), .SLOW_HALF(2)) u_bclk (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (run),
        .slow_i (cfg.slow),
        .sclk_o (sclk_o),
        .fall_o (fall)
    );

    i2s_frame_div #(.BASE_HALF(BASE_HALF)) u_frame (
        .clk     (clk),
        .rst_n   (rst_n),
        .run_i   (run),
        .fall_i  (fall),
        .ratio_i (cfg.ratio),
        .lrclk_o (lrclk_o)
    );

    // R8
    restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (!sclk_o && !lrclk_o));

endmodule

// File: tb/sim_i2s_clkgen.sv
`timescale 1ns/1ps
module sim_i2s_clkgen;

    localparam logic [7:0] KEY = 8'hA5;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0;
    logic       reg_sel = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       sclk_o;
    logic       lrclk_o;

    int tests = 0;
    int fails = 0;
    bit check_on = 0;
    bit done = 0;

    // Reference model state
    logic [7:0] m_cfg = 8'h00;
    bit         m_armed = 0;
    longint     m_t = 0;

    always #2.5 clk = ~clk;

    i2s_clkgen #(.KEY(KEY)) u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .sclk_o(sclk_o), .lrclk_o(lrclk_o)
    );

    // Behavioural model: time since the last restart, and the expected levels derived from it
    always @(posedge clk) begin
        if (!rst_n) begin
            m_cfg = 8'h00; m_armed = 0; m_t = 0;
        end else begin
            m_t = m_t + 1;
            if (reg_wr) begin
                if (!reg_sel) m_armed = (reg_wdata == KEY);
                else begin
                    if (m_armed) begin m_cfg = reg_wdata; m_t = 0; end
                    m_armed = 0;
                end
            end
        end
    end

    function automatic bit exp_sclk();
        longint h = m_cfg[1] ? 2 : 1;
        if (!m_cfg[0]) return 0;
        return bit'((m_t / h) % 2);
    endfunction

    function automatic bit exp_lr();
        longint h = m_cfg[1] ? 2 : 1;
        longint half;
        if (!m_cfg[0] || m_cfg[3:2] == 2'b00) return 0;
        half = 64'd8 << m_cfg[3:2];
        return bit'(((m_t / (2 * h)) / half) % 2);
    endfunction

    // Compare every cycle, away from the rising edge
    always @(negedge clk) begin
        if (check_on && !done) begin
            tests++;
            if (sclk_o !== exp_sclk()) begin
                fails++;
                $display("FAIL R2/R3/R6 sclk t=%0d cfg=%h actual=%b expected=%b", m_t, m_cfg, sclk_o, exp_sclk());
            end
            tests++;
            if (lrclk_o !== exp_lr()) begin
                fails++;
                $display("FAIL R4/R5/R8 lrclk t=%0d cfg=%h actual=%b expected=%b", m_t, m_cfg, lrclk_o, exp_lr());
            end
            tests++;
            if (reg_rdata !== m_cfg) begin
                fails++;
                $display("FAIL R7/R9 rdata actual=%h expected=%h", reg_rdata, m_cfg);
            end
        end
    end

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr(input bit sel, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic set_cfg(input logic [7:0] d);
        wr(1'b0, KEY);
        wr(1'b1, d);
    endtask

    // Directed check of the first frame edge after a restart (R8)
    task automatic first_edge(input logic [7:0] d, input int h, input int half);
        int wait_n;
        wr(1'b0, KEY);
        @(negedge clk);
        reg_wr = 1'b1; reg_sel = 1'b1; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
        wait_n = half * 2 * h;
        for (int i = 1; i < wait_n; i++) @(negedge clk);
        tests++;
        if (lrclk_o !== 1'b0) begin
            fails++;
            $display("FAIL R8 lrclk before half frame actual=%b expected=0", lrclk_o);
        end
        @(negedge clk);
        tests++;
        if (lrclk_o !== 1'b1) begin
            fails++;
            $display("FAIL R8 lrclk at half frame actual=%b expected=1", lrclk_o);
        end
    endtask

    initial begin
        idle(3);
        // R1: reset state
        tests++;
        if (reg_rdata !== 8'h00 || sclk_o !== 1'b0 || lrclk_o !== 1'b0) begin
            fails++;
            $display("FAIL R1 reset actual=%h/%b/%b expected=00/0/0", reg_rdata, sclk_o, lrclk_o);
        end
        rst_n = 1'b1;
        check_on = 1;
        idle(4);
        // R7: control write without the key is ignored
        wr(1'b1, 8'h05);
        idle(10);
        // R2, R4: /2 bit clock, /32 frame
        set_cfg(8'h05);
        idle(200);
        // R3, R4: /4 bit clock, /64 frame
        set_cfg(8'h0B);
        idle(600);
        // R3, R4: /4 bit clock, /128 frame
        set_cfg(8'h0F);
        idle(1100);
        // R2, R4: /2 bit clock, /128 frame
        set_cfg(8'h0D);
        idle(600);
        // R5: muted frame clock
        set_cfg(8'h01);
        idle(100);
        // R7: wrong key disarms
        wr(1'b0, KEY); wr(1'b0, 8'h5A); wr(1'b1, 8'h07);
        idle(40);
        // R7: key survives idle cycles; spare bits read back (R9)
        wr(1'b0, KEY); idle(5); wr(1'b1, 8'hF7);
        idle(300);
        // R7: repeated key still arms
        wr(1'b0, KEY); wr(1'b0, KEY); wr(1'b1, 8'h05);
        idle(50);
        // R8: rewrite same settings while running restarts
        set_cfg(8'h05);
        idle(37);
        first_edge(8'h05, 1, 16);
        first_edge(8'h0B, 2, 32);
        // R6: disable holds both low
        set_cfg(8'h0E);
        idle(50);
        tests++;
        if (sclk_o !== 1'b0 || lrclk_o !== 1'b0) begin
            fails++;
            $display("FAIL R6 disabled actual=%b/%b expected=0/0", sclk_o, lrclk_o);
        end
        // R7: key then a control write consumes arm; a second write is ignored
        set_cfg(8'h09);
        wr(1'b1, 8'h00);
        idle(300);
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            done = 1;
            tests++;
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule